// File: doc/BRIEF.md
# Two-Port Shared Memory with Same-Word Arbitration

The block is a synchronous shared memory of 2048 bytes that two agents, called left and right, reach through separate ports. Each port has its own enable, a write select, a read-data gate, an 11-bit address, write data and registered read data with a valid strobe. Both ports work independently on different words in the same cycle. When both enabled ports point at the same word, the port that got there later receives a busy flag. While that flag is up, its write is suppressed and its read is not accepted.

Two mailbox words carry doorbell interrupts between the agents. The right port writing the top word raises the left port's doorbell, and the left port reading that word lowers it. The left port writing the word just below the top raises the right port's doorbell, and the right port reading that word lowers it. A build parameter selects the arbitration source. As a master the block decides contention itself and drives its busy outputs. As a slave it takes both busy flags from inputs, so that several instances placed side by side for a wider word follow one decision.

Top module: `dpram_arb`

## Requirements
- R1: Two enabled ports at different addresses each complete a read or write in the same cycle without interfering, and written data is stored for later reads from either port.
- R2: A read is accepted when the port is enabled, the write select is 0 and busy is low. Its data appears on the port's read-data output with the valid strobe high one cycle after the accepting clock edge.
- R3: As a master, when both ports are enabled at the same address, busy is raised toward only the port whose address arrived in a later cycle. The flag stays on the same port while both ports remain enabled at a common address, and a write from the busy port does not change memory.
- R4: If both ports reach the same address in the same cycle, the left port wins and only the right port's busy flag goes high.
- R5: When the addresses stop matching, busy drops in that same cycle and the held access of the formerly blocked port proceeds. A read issued while busy is high produces no valid strobe.
- R6: As a master, busy is raised only while both enables are high and the addresses are equal. A disabled port neither causes nor suffers contention.
- R7: A read accepted with the read-data gate low produces valid strobe 0 and read data 0. Whenever the valid strobe is 0, read data is 0.
- R8: An accepted right-port write to address 0x7FF sets the left doorbell from the next cycle. An accepted left-port read of 0x7FF clears it.
- R9: An accepted left-port write to address 0x7FE sets the right doorbell from the next cycle. An accepted right-port read of 0x7FE clears it.
- R10: A doorbell that is set and cleared in the same cycle ends up set. A doorbell with neither event keeps its value.
- R11: As a slave (IS_MASTER = 0), each busy output follows its busy input in the same cycle, and a port whose busy input is high has its write suppressed.
- R12: After reset both busy flags, both doorbells, both valid strobes and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left read-data gate |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_rvalid | output | 1 | Left read data valid |
| l_int | output | 1 | Left doorbell |
| l_busy_in | input | 1 | Left busy from a master (slave build only) |
| l_busy | output | 1 | Left busy flag in effect |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right read-data gate |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |
| r_int | output | 1 | Right doorbell |
| r_busy_in | input | 1 | Right busy from a master (slave build only) |
| r_busy | output | 1 | Right busy flag in effect |

## Verification
The assertions check on every cycle that busy never goes to both ports at once, that it appears only on an address match of two enabled ports, and that it stays on the same port while the match lasts. They also check that each valid strobe traces back to an accepted read, that idle read data is zero, and that the doorbells obey their set, clear and hold rules. Which port wins a given match depends on arrival order, which only the scenarios can show: same-cycle ties, the right port arriving first, and a blocked write or read going through once the match ends. A scoreboard compares every returned word with a reference model. The slave build's obedience to external busy and the set-over-clear collision are shown by directed sequences.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
   typedef enum logic {
      WIN_LEFT  = 1'b0,
      WIN_RIGHT = 1'b1
   } winner_e;
   localparam int unsigned NPORT = 2;
   localparam int unsigned PL = 0;
   localparam int unsigned PR = 1;
endpackage

// File: rtl/dpram_arbiter.sv
`timescale 1ns/1ps
module dpram_arbiter
   import dpram_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              busy_l,
   output logic              busy_r
);
   logic              l_en_q, r_en_q, match_q;
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;
   winner_e           owner_q, winner;
   logic              l_fresh, r_fresh, match;

   // a port is fresh when its address was not already presented last cycle
   assign l_fresh = l_en && !(l_en_q && (l_addr == l_addr_q));
   assign r_fresh = r_en && !(r_en_q && (r_addr == r_addr_q));
   assign match   = l_en && r_en && (l_addr == r_addr);

   always_comb begin
      if (match_q)
         winner = owner_q;
      else if (l_fresh && !r_fresh)
         winner = WIN_RIGHT;
      else
         winner = WIN_LEFT;
   end

   assign busy_l = match && (winner == WIN_RIGHT);
   assign busy_r = match && (winner == WIN_LEFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_en_q   <= 1'b0;
         r_en_q   <= 1'b0;
         l_addr_q <= '0;
         r_addr_q <= '0;
         match_q  <= 1'b0;
         owner_q  <= WIN_LEFT;
      end else begin
         l_en_q   <= l_en;
         r_en_q   <= r_en;
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
         match_q  <= match;
         if (match)
            owner_q <= winner;
      end
   end
endmodule

// File: rtl/dpram_store.sv
`timescale 1ns/1ps
module dpram_store
   import dpram_pkg::*;
#(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORT-1:0]              we,
   input  logic [NPORT-1:0]              re,
   input  logic [NPORT-1:0]              oe,
   input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
   input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
   output logic [NPORT-1:0][DATA_W-1:0]  rdata,
   output logic [NPORT-1:0]              rvalid
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // right port is applied last; it only collides with left in slave builds
   always_ff @(posedge clk) begin
      if (we[PL]) mem[addr[PL]] <= wdata[PL];
      if (we[PR]) mem[addr[PR]] <= wdata[PR];
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata[p]  <= '0;
            rvalid[p] <= 1'b0;
         end else begin
            rvalid[p] <= re[p] && oe[p];
            rdata[p]  <= (re[p] && oe[p]) ? mem[addr[p]] : '0;
         end
      end
   end
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/dpram_arb.sv
`timescale 1ns/1ps
module dpram_arb
   import dpram_pkg::*;
#(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned DATA_W    = 8,
   parameter bit          IS_MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   output logic              l_int,
   input  logic              l_busy_in,
   output logic              l_busy,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid,
   output logic              r_int,
   input  logic              r_busy_in,
   output logic              r_busy
);
   localparam logic [ADDR_W-1:0] BOX_TO_L = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BOX_TO_R = BOX_TO_L - 1'b1;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("dpram_arb: ADDR_W must be 2..16");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dpram_arb: DATA_W must be at least 1");
   end

   // busy source: own arbiter or cascaded from a master
   if (IS_MASTER) begin : g_master
      logic unused_busy_in;
      assign unused_busy_in = l_busy_in ^ r_busy_in;
      dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
         .clk    (clk),
         .rst_n  (rst_n),
         .l_en   (l_en),
         .r_en   (r_en),
         .l_addr (l_addr),
         .r_addr (r_addr),
         .busy_l (l_busy),
         .busy_r (r_busy)
      );
   end else begin : g_slave
      assign l_busy = l_busy_in;
      assign r_busy = r_busy_in;
   end

   logic [NPORT-1:0]             we, re, oe, busy, wr, en;
   logic [NPORT-1:0][ADDR_W-1:0] addr;
   logic [NPORT-1:0][DATA_W-1:0] wdata, rdata;
   logic [NPORT-1:0]             rvalid;

   assign en    = {r_en, l_en};
   assign wr    = {r_wr, l_wr};
   assign oe    = {r_oe, l_oe};
   assign busy  = {r_busy, l_busy};
   assign addr  = {r_addr, l_addr};
   assign wdata = {r_wdata, l_wdata};

   for (genvar p = 0; p < NPORT; p++) begin : g_acc
      assign we[p] = en[p] && wr[p] && !busy[p];
      assign re[p] = en[p] && !wr[p] && !busy[p];
   end

   dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .re     (re),
      .oe     (oe),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .rvalid (rvalid)
   );

   assign l_rdata  = rdata[PL];
   assign r_rdata  = rdata[PR];
   assign l_rvalid = rvalid[PL];
   assign r_rvalid = rvalid[PR];

   dpram_mailbox u_box_l (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (we[PR] && (addr[PR] == BOX_TO_L)),
      .clr_i  (re[PL] && (addr[PL] == BOX_TO_L)),
      .flag_o (l_int)
   );

   dpram_mailbox u_box_r (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (we[PL] && (addr[PL] == BOX_TO_R)),
      .clr_i  (re[PR] && (addr[PR] == BOX_TO_R)),
      .flag_o (r_int)
   );
endmodule

// File: rtl/dpram_arb_chk.sv
`timescale 1ns/1ps
module dpram_arb_chk #(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned DATA_W    = 8,
   parameter bit          IS_MASTER = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_en,
   input logic              l_wr,
   input logic              l_oe,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_rvalid,
   input logic              l_int,
   input logic              l_busy_in,
   input logic              l_busy,
   input logic              r_en,
   input logic              r_wr,
   input logic              r_oe,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_rvalid,
   input logic              r_int,
   input logic              r_busy_in,
   input logic              r_busy
);
   localparam logic [ADDR_W-1:0] BOX_TO_L = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BOX_TO_R = BOX_TO_L - 1'b1;

   logic l_rd_ok, r_rd_ok, l_box_clr, r_box_clr;
   assign l_rd_ok   = l_en && !l_wr && !l_busy;
   assign r_rd_ok   = r_en && !r_wr && !r_busy;
   assign l_box_clr = l_rd_ok && (l_addr == BOX_TO_L);
   assign r_box_clr = r_rd_ok && (r_addr == BOX_TO_R);

   if (IS_MASTER) begin : g_m
      logic unused_chk;
      assign unused_chk = l_busy_in ^ r_busy_in;

      AST_BUSY_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
         !(l_busy && r_busy)); // R3
      AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
         (l_busy || r_busy) |-> (l_en && r_en && l_addr == r_addr)); // R6
      AST_OWNER_KEPT_R: assert property (@(posedge clk) disable iff (!rst_n)
         r_busy |=> (!(l_en && r_en && l_addr == r_addr) || r_busy)); // R3
      AST_OWNER_KEPT_L: assert property (@(posedge clk) disable iff (!rst_n)
         l_busy |=> (!(l_en && r_en && l_addr == r_addr) || l_busy)); // R3
   end else begin : g_s
      AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (l_busy == l_busy_in) && (r_busy == r_busy_in)); // R11
   end

   AST_LVALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      l_rvalid |-> ($past(rst_n) && $past(l_rd_ok && l_oe))); // R5
   AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      r_rvalid |-> ($past(rst_n) && $past(r_rd_ok && r_oe))); // R5
   AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_rvalid |-> l_rdata == '0) and (!r_rvalid |-> r_rdata == '0)); // R7
   AST_LINT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(r_en && r_wr && !r_busy && r_addr == BOX_TO_L))
      |-> l_int); // R8
   AST_RINT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(l_en && l_wr && !l_busy && l_addr == BOX_TO_R))
      |-> r_int); // R9
   AST_LINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(l_int) && !$past(l_box_clr)) |-> l_int); // R10
   AST_RINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(r_int) && !$past(r_box_clr)) |-> r_int); // R10
endmodule

bind dpram_arb dpram_arb_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_MASTER(IS_MASTER)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
   .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_int(l_int),
   .l_busy_in(l_busy_in), .l_busy(l_busy),
   .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
   .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_int(r_int),
   .r_busy_in(r_busy_in), .r_busy(r_busy)
);

// File: tb/tb_dpram_arb.sv
`timescale 1ns/1ps
module tb_dpram_arb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        l_en = 0, l_wr = 0, l_oe = 0, r_en = 0, r_wr = 0, r_oe = 0;
   logic [10:0] l_addr = '0, r_addr = '0;
   logic [7:0]  l_wd = '0, r_wd = '0;
   logic        sb_l = 0, sb_r = 0;

   logic [7:0] l_rd, r_rd, s_lrd, s_rrd;
   logic       l_rv, r_rv, li, ri, bl, br;
   logic       s_lrv, s_rrv, s_li, s_ri, s_bl, s_br;

   dpram_arb dut (
      .clk(clk), .rst_n(rst_n),
      .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wd),
      .l_rdata(l_rd), .l_rvalid(l_rv), .l_int(li), .l_busy_in(1'b0), .l_busy(bl),
      .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wd),
      .r_rdata(r_rd), .r_rvalid(r_rv), .r_int(ri), .r_busy_in(1'b0), .r_busy(br)
   );

   dpram_arb #(.IS_MASTER(1'b0)) dut_s (
      .clk(clk), .rst_n(rst_n),
      .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wd),
      .l_rdata(s_lrd), .l_rvalid(s_lrv), .l_int(s_li), .l_busy_in(sb_l), .l_busy(s_bl),
      .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wd),
      .r_rdata(s_rrd), .r_rvalid(s_rrv), .r_int(s_ri), .r_busy_in(sb_r), .r_busy(s_br)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [7:0] ref_mem [int];
   logic [7:0] q_l[$], q_r[$];

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every valid strobe must match the oldest expected word
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (l_rv) begin
            if (q_l.size() == 0) chk("R2 left unexpected valid", 1, 0);
            else chk("R2 left read data", l_rd, q_l.pop_front());
         end
         if (r_rv) begin
            if (q_r.size() == 0) chk("R2 right unexpected valid", 1, 0);
            else chk("R2 right read data", r_rd, q_r.pop_front());
         end
      end
   end

   // driver: apply one cycle, check busy, push expected results
   task automatic drive(input bit le, lw, lo, input logic [10:0] la, input logic [7:0] ld,
                        input bit re, rw, ro, input logic [10:0] ra, input logic [7:0] rd,
                        input bit xbl, xbr, input string req,
                        input bit nsl = 0, input bit nsr = 0);
      @(negedge clk);
      l_en = le; l_wr = lw; l_oe = lo; l_addr = la; l_wd = ld;
      r_en = re; r_wr = rw; r_oe = ro; r_addr = ra; r_wd = rd;
      sb_l = nsl; sb_r = nsr;
      #1;
      chk({req, " left busy"}, bl, xbl);
      chk({req, " right busy"}, br, xbr);
      if (le && !lw && lo && !xbl) q_l.push_back(ref_mem[int'(la)]);
      if (re && !rw && ro && !xbr) q_r.push_back(ref_mem[int'(ra)]);
      if (le && lw && !xbl) ref_mem[int'(la)] = ld;
      if (re && rw && !xbr) ref_mem[int'(ra)] = rd;
   endtask

   task automatic idle();
      drive(0, 0, 0, 11'h0, 8'h0, 0, 0, 0, 11'h0, 8'h0, 0, 0, "idle");
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12 reset state
      chk("R12 busy", {bl, br}, 0);
      chk("R12 doorbells", {li, ri}, 0);
      chk("R12 valid", {l_rv, r_rv}, 0);
      chk("R12 read data", {l_rd, r_rd}, 0);

      // R1 independent writes then crossed reads
      drive(1, 1, 1, 11'h010, 8'hA5, 1, 1, 1, 11'h020, 8'h5A, 0, 0, "R1");
      drive(1, 0, 1, 11'h020, 8'h0, 1, 0, 1, 11'h010, 8'h0, 0, 0, "R1");
      idle();

      // R4 same-cycle arrival: left wins; R3 flag kept while match holds
      drive(1, 1, 1, 11'h030, 8'h11, 1, 1, 1, 11'h030, 8'h22, 0, 1, "R4");
      drive(1, 1, 1, 11'h030, 8'h11, 1, 1, 1, 11'h030, 8'h22, 0, 1, "R3 hold");
      idle();
      drive(1, 0, 1, 11'h030, 8'h0, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R3 blocked write");

      // R3 right arrives first, left later gets busy; R5 release
      drive(0, 0, 0, 11'h0, 8'h0, 1, 1, 1, 11'h040, 8'h33, 0, 0, "R1");
      idle();
      drive(0, 0, 0, 11'h0, 8'h0, 1, 0, 1, 11'h040, 8'h0, 0, 0, "R3");
      drive(1, 1, 1, 11'h040, 8'h77, 1, 0, 1, 11'h040, 8'h0, 1, 0, "R3 later arrival");
      drive(1, 1, 1, 11'h040, 8'h77, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R5 release");
      drive(0, 0, 0, 11'h0, 8'h0, 1, 0, 1, 11'h040, 8'h0, 0, 0, "R5 write landed");

      // R5 blocked read gives no strobe, then succeeds
      drive(0, 0, 0, 11'h0, 8'h0, 1, 1, 1, 11'h050, 8'h44, 0, 0, "R5");
      drive(1, 0, 1, 11'h050, 8'h0, 1, 1, 1, 11'h050, 8'h45, 1, 0, "R5 blocked read");
      drive(1, 0, 1, 11'h050, 8'h0, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R5 read after release");

      // R6 disabled port at the same address causes no contention
      drive(0, 0, 0, 11'h010, 8'h0, 1, 0, 1, 11'h010, 8'h0, 0, 0, "R6");

      // R7 read with gate low
      drive(1, 0, 0, 11'h010, 8'h0, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R7");
      idle();
      chk("R7 gated read data", l_rd, 0);
      chk("R7 gated valid", l_rv, 0);

      // R8 left doorbell
      drive(0, 0, 0, 11'h0, 8'h0, 1, 1, 1, 11'h7FF, 8'hC3, 0, 0, "R8");
      idle();
      chk("R8 left doorbell set", li, 1);
      chk("R8 right doorbell untouched", ri, 0);
      drive(1, 0, 1, 11'h7FF, 8'h0, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R8");
      idle();
      chk("R8 left doorbell cleared", li, 0);

      // R9 right doorbell
      drive(1, 1, 1, 11'h7FE, 8'h3C, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R9");
      idle();
      chk("R9 right doorbell set", ri, 1);
      chk("R9 left doorbell untouched", li, 0);
      drive(0, 0, 0, 11'h0, 8'h0, 1, 0, 1, 11'h7FE, 8'h0, 0, 0, "R9");
      idle();
      chk("R9 right doorbell cleared", ri, 0);

      // R11 slave obeys external busy
      drive(1, 1, 1, 11'h100, 8'h11, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R11");
      drive(1, 1, 1, 11'h100, 8'h22, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R11", 1, 0);
      chk("R11 slave left busy follows input", s_bl, 1);
      chk("R11 slave right busy follows input", s_br, 0);
      drive(1, 0, 1, 11'h100, 8'h0, 0, 0, 0, 11'h0, 8'h0, 0, 0, "R11");
      idle();
      chk("R11 slave write suppressed", s_lrd, 8'h11);

      // R10 set and clear together: slave has no busy, so both happen
      drive(0, 0, 0, 11'h0, 8'h0, 1, 1, 1, 11'h7FF, 8'h99, 0, 0, "R10");
      idle();
      chk("R10 slave doorbell set", s_li, 1);
      drive(1, 0, 1, 11'h7FF, 8'h0, 1, 1, 1, 11'h7FF, 8'h9A, 0, 1, "R10");
      idle();
      chk("R10 set wins over clear", s_li, 1);
      chk("R8 master clear with blocked set", li, 0);

      idle();
      idle();
      chk("R2 left scoreboard drained", q_l.size(), 0);
      chk("R2 right scoreboard drained", q_r.size(), 0);
      done = 1;
      summary();
   end
endmodule